// File: doc/BRIEF.md
# Tick compare and soft interrupt unit

This unit keeps three pieces of processor timer and interrupt state: a 16-bit soft-interrupt pending register, a free-running 64-bit tick counter, and a 64-bit compare register. The top bit of the counter is a trap flag that hides the count from unprivileged code. The top bit of the compare register disables compare interrupts. When the compare is enabled and armed, and the count reaches the compare value, the unit sets pending bit 0. That bit stays set until software clears it, and it drives the tick interrupt request.

Software reaches the unit through a single-cycle register port. The port carries an enable, a write strobe, a 3-bit register select, 64-bit write data and a 2-bit privilege level. Read data and a fault code are combinational responses in the same cycle, and an accepted write takes effect at the next clock edge. The pending register has two write-only aliases. One ORs the written data into the pending value and the other clears the written bits, so software can change single bits without a read-modify-write.

Every access is checked against the privilege level before any state changes. The unit reports the highest pending soft-interrupt level. It also pulses a re-check request to the core when a write raises that level. The compare path is a three-state machine:
- CMP_OFF: the compare is disabled.
- CMP_IDLE: the compare is enabled but no event is pending.
- CMP_ARMED: a future match is pending.

It moves between these states as follows:
- A compare write with the disable bit set goes to CMP_OFF.
- A compare write with the disable bit clear and a value above the count goes to CMP_ARMED.
- Any other compare write goes to CMP_IDLE.
- In CMP_ARMED, a match fires and goes to CMP_IDLE.

Top module: `tsu_unit`

## Requirements
- R1: After reset the count, the trap flag and the pending register are zero, and the compare register holds disable=1 with value 0. The read data, fault (0), level, tick request and re-check outputs are all zero.
- R2: The count increments by one on every clock edge out of reset unless it is written. A counter read (select 4) returns the flag in bit 63 and the count in bits 62:0.
- R3: A counter write loads bits 62:0 into the count and bit 63 into the trap flag, but only at hypervisor level (privilege 2 or 3). At user level (0) the write faults with privileged-opcode (code 1), and at supervisor level (1) it faults with privileged-action (code 2). A faulted write leaves the count running unchanged.
- R4: A counter read at user level while the trap flag is set faults with privileged-action (code 2) and returns zero. With the flag clear, the read succeeds at any level.
- R5: Any access at user level to the pending register (select 0), the set alias (1), the clear alias (2) or the compare register (3) faults with privileged-opcode (code 1), returns zero and changes no state.
- R6: A privileged write to select 0 replaces the pending value with write data bits 15:0. A write to the set alias stores pending OR data. A write to the clear alias stores pending AND NOT data. Reads of select 0 return the pending value in bits 15:0.
- R7: The level output is the index of the highest set pending bit among bits 15:1, or 0 when none of them is set.
- R8: The re-check output is high for exactly the one cycle after an accepted pending-family write whose result has a higher level than the previous value, and it is low otherwise.
- R9: A privileged compare write with bit 63 clear and bits 62:0 above the current count arms the compare. In the cycle in which the count equals the value, the next clock edge sets pending bit 0. The tick request output equals pending bit 0, and the bit stays set until software clears it. A read of select 3 returns the compare register.
- R10: A compare write whose value is at or below the current count arms nothing and never sets pending bit 0.
- R11: While the compare disable bit is set no match is raised, and writing the disable bit cancels an armed compare.
- R12: Selects 5 to 7, and privileged reads of the set or clear alias, fault with illegal (code 3), return zero and change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en_i | input | 1 | Register access this cycle |
| acc_we_i | input | 1 | 1 = write, 0 = read |
| acc_sel_i | input | 3 | 0 pending, 1 set alias, 2 clear alias, 3 compare, 4 counter |
| acc_wdata_i | input | 64 | Write data |
| priv_i | input | 2 | 0 user, 1 supervisor, 2 or 3 hypervisor |
| acc_rdata_o | output | 64 | Read data, zero on fault or no access |
| fault_o | output | 2 | 0 none, 1 privileged-opcode, 2 privileged-action, 3 illegal |
| int_level_o | output | 4 | Highest pending level among bits 15:1 |
| tick_irq_o | output | 1 | Tick compare interrupt request (pending bit 0) |
| recheck_o | output | 1 | One-cycle request to re-evaluate interrupts |

## Verification
The bench targets the following corner cases:
- A compare written equal to the current count. A design that armed on equality would fire once the count wrapped, or at once.
- A compare disabled while armed. A design that kept the arm would set pending bit 0 at the old value.
- A user read with the trap flag set. A wrong design would leak the count or report the wrong fault code.
- A supervisor write to the counter. A wrong design would load the count or report the wrong fault code.
- Clear and set alias writes, including clears of the match bit. A design that loaded the written data directly would get pending values that diverge from the model on the next random write.
- Writes that raise the level and writes that lower it. A wrong design would pulse re-check on the wrong writes.

Randomised access sequences keep the compare value a few counts ahead of the model counter, so matches and same-cycle write collisions occur often.

// File: rtl/tsu_pkg.sv
package tsu_pkg;

    typedef enum logic [1:0] {
        FLT_NONE     = 2'd0,
        FLT_PRIV_OPC = 2'd1,
        FLT_PRIV_ACT = 2'd2,
        FLT_ILLEGAL  = 2'd3
    } flt_e;

    typedef enum logic [1:0] {
        PW_LOAD = 2'd0,
        PW_SET  = 2'd1,
        PW_CLR  = 2'd2
    } pw_mode_e;

    typedef enum logic [1:0] {
        RD_ZERO = 2'd0,
        RD_PEND = 2'd1,
        RD_CMPR = 2'd2,
        RD_CNT  = 2'd3
    } rd_src_e;

    typedef enum logic [1:0] {
        CMP_OFF   = 2'd0,
        CMP_IDLE  = 2'd1,
        CMP_ARMED = 2'd2
    } cmp_st_e;

    localparam logic [2:0] SEL_PEND = 3'd0;
    localparam logic [2:0] SEL_SET  = 3'd1;
    localparam logic [2:0] SEL_CLR  = 3'd2;
    localparam logic [2:0] SEL_CMPR = 3'd3;
    localparam logic [2:0] SEL_CNT  = 3'd4;

    localparam logic [1:0] PRV_USER = 2'd0;
    localparam logic [1:0] PRV_SUP  = 2'd1;

endpackage

// File: rtl/tsu_access_dec.sv
module tsu_access_dec
    import tsu_pkg::*;
(
    input  logic       en_i,
    input  logic       we_i,
    input  logic [2:0] sel_i,
    input  logic [1:0] priv_i,
    input  logic       npt_i,
    output flt_e       flt_o,
    output rd_src_e    rd_src_o,
    output logic       pend_wr_o,
    output pw_mode_e   pend_mode_o,
    output logic       cmp_wr_o,
    output logic       cnt_wr_o
);

    logic is_user;
    logic is_sup;

    assign is_user = (priv_i == PRV_USER);
    assign is_sup  = (priv_i == PRV_SUP);

    always_comb begin
        flt_o       = FLT_NONE;
        rd_src_o    = RD_ZERO;
        pend_wr_o   = 1'b0;
        pend_mode_o = PW_LOAD;
        cmp_wr_o    = 1'b0;
        cnt_wr_o    = 1'b0;
        if (en_i) begin
            case (sel_i)
                SEL_PEND: begin
                    if (is_user)   flt_o     = FLT_PRIV_OPC;
                    else if (we_i) pend_wr_o = 1'b1;
                    else           rd_src_o  = RD_PEND;
                end
                SEL_SET, SEL_CLR: begin
                    if (is_user)    flt_o = FLT_PRIV_OPC;
                    else if (!we_i) flt_o = FLT_ILLEGAL;
                    else begin
                        pend_wr_o   = 1'b1;
                        pend_mode_o = (sel_i == SEL_SET) ? PW_SET : PW_CLR;
                    end
                end
                SEL_CMPR: begin
                    if (is_user)   flt_o    = FLT_PRIV_OPC;
                    else if (we_i) cmp_wr_o = 1'b1;
                    else           rd_src_o = RD_CMPR;
                end
                SEL_CNT: begin
                    if (we_i) begin
                        if (is_user)     flt_o    = FLT_PRIV_OPC;
                        else if (is_sup) flt_o    = FLT_PRIV_ACT;
                        else             cnt_wr_o = 1'b1;
                    end else begin
                        if (is_user && npt_i) flt_o    = FLT_PRIV_ACT;
                        else                  rd_src_o = RD_CNT;
                    end
                end
                default: flt_o = FLT_ILLEGAL;
            endcase
        end
    end

endmodule

// File: rtl/tsu_tick_ctr.sv
module tsu_tick_ctr #(
    parameter int CNT_W = 64,
    localparam int VAL_W = CNT_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [VAL_W-1:0] cnt_o,
    output logic             npt_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
            npt_o <= 1'b0;
        end else if (wr_i) begin
            cnt_o <= wdata_i[VAL_W-1:0];
            npt_o <= wdata_i[CNT_W-1];
        end else begin
            cnt_o <= cnt_o + VAL_W'(1);
        end
    end

endmodule

// File: rtl/tsu_cmp_fsm.sv
module tsu_cmp_fsm
    import tsu_pkg::*;
#(
    parameter int CNT_W = 64,
    localparam int VAL_W = CNT_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic [VAL_W-1:0] cnt_i,
    output logic             dis_o,
    output logic [VAL_W-1:0] val_o,
    output logic             hit_o
);

    cmp_st_e state_q;
    cmp_st_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CMP_OFF;
            dis_o   <= 1'b1;
            val_o   <= '0;
        end else begin
            state_q <= state_d;
            if (wr_i) begin
                dis_o <= wdata_i[CNT_W-1];
                val_o <= wdata_i[VAL_W-1:0];
            end
        end
    end

    always_comb begin
        state_d = state_q;
        if (wr_i) begin
            if (wdata_i[CNT_W-1])             state_d = CMP_OFF;
            else if (wdata_i[VAL_W-1:0] > cnt_i) state_d = CMP_ARMED;
            else                              state_d = CMP_IDLE;
        end else begin
            unique case (state_q)
                CMP_OFF:   state_d = CMP_OFF;
                CMP_IDLE:  state_d = CMP_IDLE;
                CMP_ARMED: if (cnt_i == val_o) state_d = CMP_IDLE;
                default:   state_d = CMP_OFF;
            endcase
        end
    end

    always_comb begin
        hit_o = (state_q == CMP_ARMED) && (cnt_i == val_o);
    end

endmodule

// File: rtl/tsu_pend_reg.sv
module tsu_pend_reg
    import tsu_pkg::*;
#(
    parameter int PEND_W = 16,
    localparam int LVL_W = $clog2(PEND_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  pw_mode_e          mode_i,
    input  logic [PEND_W-1:0] wdata_i,
    input  logic              hit_i,
    output logic [PEND_W-1:0] pend_o,
    output logic [LVL_W-1:0]  lvl_o,
    output logic              recheck_o
);

    function automatic logic [LVL_W-1:0] hi_idx(input logic [PEND_W-1:0] v);
        logic [LVL_W-1:0] r;
        r = '0;
        for (int i = 1; i < PEND_W; i++) begin
            if (v[i]) r = LVL_W'(i);
        end
        return r;
    endfunction

    logic [PEND_W-1:0] wres;
    logic [PEND_W-1:0] hit_vec;

    always_comb begin
        unique case (mode_i)
            PW_SET:  wres = pend_o | wdata_i;
            PW_CLR:  wres = pend_o & ~wdata_i;
            default: wres = wdata_i;
        endcase
    end

    assign hit_vec = {{(PEND_W-1){1'b0}}, hit_i};
    assign lvl_o   = hi_idx(pend_o);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_o    <= '0;
            recheck_o <= 1'b0;
        end else begin
            pend_o    <= (wr_i ? wres : pend_o) | hit_vec;
            recheck_o <= wr_i && (hi_idx(wres) > hi_idx(pend_o));
        end
    end

endmodule

// File: rtl/tsu_unit.sv
module tsu_unit
    import tsu_pkg::*;
#(
    parameter int CNT_W = 64,
    parameter int PEND_W = 16,
    localparam int VAL_W = CNT_W - 1,
    localparam int LVL_W = $clog2(PEND_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_en_i,
    input  logic             acc_we_i,
    input  logic [2:0]       acc_sel_i,
    input  logic [CNT_W-1:0] acc_wdata_i,
    input  logic [1:0]       priv_i,
    output logic [CNT_W-1:0] acc_rdata_o,
    output logic [1:0]       fault_o,
    output logic [LVL_W-1:0] int_level_o,
    output logic             tick_irq_o,
    output logic             recheck_o
);

    flt_e              flt_s;
    rd_src_e           rd_src_s;
    logic              pend_wr_s;
    pw_mode_e          pend_mode_s;
    logic              cmp_wr_s;
    logic              cnt_wr_s;
    logic [VAL_W-1:0]  cnt_q;
    logic              npt_q;
    logic              dis_q;
    logic [VAL_W-1:0]  cv_q;
    logic              hit_s;
    logic [PEND_W-1:0] pend_q;

    tsu_access_dec dec_i (
        .en_i        (acc_en_i),
        .we_i        (acc_we_i),
        .sel_i       (acc_sel_i),
        .priv_i      (priv_i),
        .npt_i       (npt_q),
        .flt_o       (flt_s),
        .rd_src_o    (rd_src_s),
        .pend_wr_o   (pend_wr_s),
        .pend_mode_o (pend_mode_s),
        .cmp_wr_o    (cmp_wr_s),
        .cnt_wr_o    (cnt_wr_s)
    );

    tsu_tick_ctr #(.CNT_W(CNT_W)) ctr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (cnt_wr_s),
        .wdata_i (acc_wdata_i),
        .cnt_o   (cnt_q),
        .npt_o   (npt_q)
    );

    tsu_cmp_fsm #(.CNT_W(CNT_W)) cmp_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (cmp_wr_s),
        .wdata_i (acc_wdata_i),
        .cnt_i   (cnt_q),
        .dis_o   (dis_q),
        .val_o   (cv_q),
        .hit_o   (hit_s)
    );

    tsu_pend_reg #(.PEND_W(PEND_W)) pend_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (pend_wr_s),
        .mode_i    (pend_mode_s),
        .wdata_i   (acc_wdata_i[PEND_W-1:0]),
        .hit_i     (hit_s),
        .pend_o    (pend_q),
        .lvl_o     (int_level_o),
        .recheck_o (recheck_o)
    );

    always_comb begin
        unique case (rd_src_s)
            RD_PEND: acc_rdata_o = {{(CNT_W-PEND_W){1'b0}}, pend_q};
            RD_CMPR: acc_rdata_o = {dis_q, cv_q};
            RD_CNT:  acc_rdata_o = {npt_q, cnt_q};
            default: acc_rdata_o = '0;
        endcase
    end

    assign fault_o    = flt_s;
    assign tick_irq_o = pend_q[0];

endmodule

// File: rtl/tsu_unit_chk.sv
module tsu_unit_chk #(
    parameter int CNT_W = 64,
    parameter int PEND_W = 16,
    localparam int VAL_W = CNT_W - 1,
    localparam int LVL_W = $clog2(PEND_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_en_i,
    input logic              acc_we_i,
    input logic [2:0]        acc_sel_i,
    input logic [PEND_W-1:0] wd_lo,
    input logic [1:0]        priv_i,
    input logic [CNT_W-1:0]  acc_rdata_o,
    input logic [1:0]        fault_o,
    input logic [LVL_W-1:0]  int_level_o,
    input logic              tick_irq_o,
    input logic              recheck_o,
    input logic [VAL_W-1:0]  cnt_q,
    input logic              npt_q,
    input logic              dis_q,
    input logic [VAL_W-1:0]  cv_q,
    input logic              hit_s,
    input logic              cnt_wr_s,
    input logic [PEND_W-1:0] pend_q
);

    logic user_acc;
    logic [PEND_W-1:0] hit_vec;

    assign user_acc = acc_en_i && (priv_i == 2'd0) && (acc_sel_i <= 3'd3);
    assign hit_vec  = {{(PEND_W-1){1'b0}}, hit_s};

    assert_user_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
        user_acc |-> (fault_o == 2'd1) && (acc_rdata_o == '0));

    assert_user_keeps_cmp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        user_acc |=> $stable(dis_q) && $stable(cv_q));

    assert_user_keeps_pend_R5: assert property (@(posedge clk) disable iff (!rst_n)
        user_acc |=> pend_q == ($past(pend_q) | $past(hit_vec)));

    assert_set_alias_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en_i && acc_we_i && priv_i != 2'd0 && acc_sel_i == 3'd1)
        |=> pend_q == ($past(pend_q) | $past(wd_lo) | $past(hit_vec)));

    assert_clr_alias_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en_i && acc_we_i && priv_i != 2'd0 && acc_sel_i == 3'd2)
        |=> pend_q == (($past(pend_q) & ~$past(wd_lo)) | $past(hit_vec)));

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_wr_s |=> cnt_q == $past(cnt_q) + VAL_W'(1));

    assert_trap_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en_i && !acc_we_i && acc_sel_i == 3'd4 && priv_i == 2'd0 && npt_q)
        |-> (fault_o == 2'd2) && (acc_rdata_o == '0));

    assert_no_hit_disabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
        dis_q |-> !hit_s);

    assert_hit_on_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hit_s |-> cnt_q == cv_q);

    assert_hit_raises_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hit_s |=> tick_irq_o);

    assert_recheck_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        recheck_o |-> int_level_o > $past(int_level_o));

    assert_illegal_sel_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en_i && acc_sel_i > 3'd4) |-> (fault_o == 2'd3) && (acc_rdata_o == '0));

endmodule

bind tsu_unit tsu_unit_chk #(.CNT_W(CNT_W), .PEND_W(PEND_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_en_i    (acc_en_i),
    .acc_we_i    (acc_we_i),
    .acc_sel_i   (acc_sel_i),
    .wd_lo       (acc_wdata_i[PEND_W-1:0]),
    .priv_i      (priv_i),
    .acc_rdata_o (acc_rdata_o),
    .fault_o     (fault_o),
    .int_level_o (int_level_o),
    .tick_irq_o  (tick_irq_o),
    .recheck_o   (recheck_o),
    .cnt_q       (cnt_q),
    .npt_q       (npt_q),
    .dis_q       (dis_q),
    .cv_q        (cv_q),
    .hit_s       (hit_s),
    .cnt_wr_s    (cnt_wr_s),
    .pend_q      (pend_q)
);

// File: tb/tsu_unit_tb_top.sv
`timescale 1ns/1ps
module tsu_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        we = 1'b0;
    logic [2:0]  sel = 3'd0;
    logic [63:0] wd = '0;
    logic [1:0]  priv = 2'd0;
    logic [63:0] rdata;
    logic [1:0]  fault;
    logic [3:0]  lvl;
    logic        irq;
    logic        rchk;

    always #4 clk = ~clk;

    tsu_unit dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_en_i    (en),
        .acc_we_i    (we),
        .acc_sel_i   (sel),
        .acc_wdata_i (wd),
        .priv_i      (priv),
        .acc_rdata_o (rdata),
        .fault_o     (fault),
        .int_level_o (lvl),
        .tick_irq_o  (irq),
        .recheck_o   (rchk)
    );

    int n_chk = 0;
    int n_bad = 0;

    logic [62:0] m_cnt, m_cv;
    logic        m_npt, m_dis, m_rc;
    logic [15:0] m_pend;
    int          m_st;

    function automatic logic [3:0] hi_idx(input logic [15:0] p);
        logic [3:0] r = 4'd0;
        for (int i = 1; i < 16; i++) if (p[i]) r = 4'(i);
        return r;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // act: 0 none, 1 load, 2 set, 3 clr, 4 compare write, 5 counter write
    task automatic expect_resp(output logic [1:0] f, output logic [63:0] rd,
                               output int act);
        f = 2'd0; rd = '0; act = 0;
        if (en) begin
            if (sel <= 3'd3 && priv == 2'd0) f = 2'd1;
            else if (sel == 3'd0) begin
                if (we) act = 1; else rd = {48'd0, m_pend};
            end else if (sel == 3'd1 || sel == 3'd2) begin
                if (we) act = (sel == 3'd1) ? 2 : 3; else f = 2'd3;
            end else if (sel == 3'd3) begin
                if (we) act = 4; else rd = {m_dis, m_cv};
            end else if (sel == 3'd4) begin
                if (we) begin
                    if (priv == 2'd0) f = 2'd1;
                    else if (priv == 2'd1) f = 2'd2;
                    else act = 5;
                end else begin
                    if (priv == 2'd0 && m_npt) f = 2'd2;
                    else rd = {m_npt, m_cnt};
                end
            end else f = 2'd3;
        end
    endtask

    task automatic cyc(input logic e, input logic w, input logic [2:0] s,
                       input logic [1:0] p, input logic [63:0] d);
        logic [1:0]  ef;
        logic [63:0] erd;
        int          act;
        string       tf, tr;
        logic        fire, rc;
        logic [15:0] np;
        en = e; we = w; sel = s; priv = p; wd = d;
        #1;
        expect_resp(ef, erd, act);
        if (s <= 3'd3 && p == 2'd0)  begin tf = "R5"; tr = "R5"; end
        else if (s <= 3'd2)          begin tf = "R6"; tr = "R6"; end
        else if (s == 3'd3)          begin tf = "R9"; tr = "R9"; end
        else if (s == 3'd4)          begin tf = w ? "R3" : "R4"; tr = "R2"; end
        else                         begin tf = "R12"; tr = "R12"; end
        if (!e) begin tf = "R12"; tr = "R12"; end
        check(tf, "fault", 64'(fault), 64'(ef));
        check(tr, "rdata", rdata, erd);
        check("R7", "level", 64'(lvl), 64'(hi_idx(m_pend)));
        check("R9", "tick_irq", 64'(irq), 64'(m_pend[0]));
        check("R8", "recheck", 64'(rchk), 64'(m_rc));
        @(posedge clk);
        fire = (m_st == 2) && (m_cnt == m_cv);
        np = m_pend;
        if (act == 1) np = d[15:0];
        else if (act == 2) np = m_pend | d[15:0];
        else if (act == 3) np = m_pend & ~d[15:0];
        rc = (act >= 1 && act <= 3) && (hi_idx(np) > hi_idx(m_pend));
        if (fire) np[0] = 1'b1;
        if (act == 4) begin
            m_dis = d[63];
            m_cv  = d[62:0];
            m_st  = d[63] ? 0 : ((d[62:0] > m_cnt) ? 2 : 1);
        end else if (fire) m_st = 1;
        if (act == 5) begin
            m_cnt = d[62:0];
            m_npt = d[63];
        end else m_cnt = m_cnt + 63'd1;
        m_pend = np;
        m_rc   = rc;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 3'd0, 2'd0, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int unsigned seed = 32'h5EED_0042;
        void'($urandom(seed));
        m_cnt = '0; m_cv = '0; m_npt = 1'b0; m_dis = 1'b1;
        m_pend = '0; m_st = 0; m_rc = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state at the ports
        check("R1", "rdata", rdata, '0);
        check("R1", "fault", 64'(fault), 64'd0);
        check("R1", "level", 64'(lvl), 64'd0);
        check("R1", "irq", 64'(irq), 64'd0);
        check("R1", "recheck", 64'(rchk), 64'd0);
        cyc(1'b1, 1'b0, 3'd3, 2'd2, '0);
        check("R1", "compare reset", {1'b1, 63'd0}, {m_dis, m_cv});
        // R2 counter reads
        cyc(1'b1, 1'b0, 3'd4, 2'd2, '0);
        idle(3);
        cyc(1'b1, 1'b0, 3'd4, 2'd0, '0);
        // R3 counter write privilege
        cyc(1'b1, 1'b1, 3'd4, 2'd0, 64'h0000_0000_0000_0777);
        cyc(1'b1, 1'b1, 3'd4, 2'd1, 64'h0000_0000_0000_0777);
        cyc(1'b1, 1'b1, 3'd4, 2'd2, 64'h8000_0000_0000_0100);
        cyc(1'b1, 1'b0, 3'd4, 2'd1, '0);
        // R4 trap flag read at user level
        cyc(1'b1, 1'b0, 3'd4, 2'd0, '0);
        check("R4", "trap read data", rdata, '0);
        cyc(1'b1, 1'b1, 3'd4, 2'd3, 64'h0000_0000_0000_0200);
        cyc(1'b1, 1'b0, 3'd4, 2'd0, '0);
        // R6 / R8 pending aliases
        cyc(1'b1, 1'b1, 3'd0, 2'd1, 64'h0012);
        cyc(1'b1, 1'b1, 3'd1, 2'd1, 64'h0100);
        cyc(1'b1, 1'b0, 3'd0, 2'd1, '0);
        check("R8", "recheck after set", 64'(rchk), 64'd0);
        cyc(1'b1, 1'b1, 3'd2, 2'd2, 64'h0110);
        cyc(1'b1, 1'b0, 3'd0, 2'd1, '0);
        check("R6", "clear alias", rdata, 64'h0002);
        // R5 user write leaves state
        cyc(1'b1, 1'b1, 3'd0, 2'd0, 64'hFFFF);
        cyc(1'b1, 1'b1, 3'd3, 2'd0, 64'h0000_0000_0000_9999);
        cyc(1'b1, 1'b0, 3'd0, 2'd1, '0);
        check("R5", "pend kept", rdata, 64'h0002);
        // R9 arm and fire
        cyc(1'b1, 1'b1, 3'd3, 2'd1, {1'b0, m_cnt + 63'd5});
        idle(8);
        check("R9", "irq after match", 64'(irq), 64'd1);
        idle(5);
        check("R9", "irq held", 64'(irq), 64'd1);
        cyc(1'b1, 1'b1, 3'd2, 2'd1, 64'h0001);
        // R10 compare at or below count
        cyc(1'b1, 1'b1, 3'd3, 2'd1, {1'b0, m_cnt});
        idle(10);
        check("R10", "no fire equal", 64'(irq), 64'd0);
        cyc(1'b1, 1'b1, 3'd3, 2'd1, {1'b0, m_cnt - 63'd3});
        idle(10);
        check("R10", "no fire below", 64'(irq), 64'd0);
        // R11 disable cancels armed compare
        cyc(1'b1, 1'b1, 3'd3, 2'd1, {1'b0, m_cnt + 63'd20});
        idle(3);
        cyc(1'b1, 1'b1, 3'd3, 2'd1, {1'b1, m_cv});
        idle(25);
        check("R11", "cancelled", 64'(irq), 64'd0);
        cyc(1'b1, 1'b1, 3'd3, 2'd2, {1'b1, m_cnt + 63'd4});
        idle(8);
        check("R11", "disabled", 64'(irq), 64'd0);
        // R12 illegal selects and alias reads
        cyc(1'b1, 1'b0, 3'd6, 2'd2, '0);
        cyc(1'b1, 1'b1, 3'd7, 2'd2, 64'hFFFF);
        cyc(1'b1, 1'b0, 3'd1, 2'd1, '0);
        cyc(1'b1, 1'b0, 3'd2, 2'd2, '0);
        // random mix
        for (int k = 0; k < 4000; k++) begin
            logic [2:0]  s = 3'($urandom % 8);
            logic        w = 1'($urandom % 2);
            logic [1:0]  p = 2'($urandom % 4);
            logic        e = ($urandom % 8) != 0;
            logic [63:0] d = {$urandom, $urandom};
            if (s == 3'd3)
                d = {($urandom % 6) == 0, m_cnt + 63'($urandom % 40) - 63'd5};
            else if (s == 3'd4 && ($urandom % 4) != 0)
                d = {1'($urandom % 2), m_cnt + 63'($urandom % 64)};
            cyc(e, w, s, p, d);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule